// File: doc/BRIEF.md
# Filtered Tamper Input Detector

This block watches two external tamper inputs and raises a sticky flag per input when a tamper event is accepted. Each input is resynchronised into the clock domain and then judged in one of two ways. In edge mode one transition of the chosen direction is enough. In level mode the input is sampled only at a periodic sample point, and it must be seen active at a run of consecutive sample points before the event counts.

In level mode the sample points come from a shared free-running divider of the base clock. A short pull-up precharge window runs just before each sample, so that an open pad can charge before it is read. Accepted events can also pulse a timestamp request. A single interrupt enable merges both flags onto one interrupt line. The flags stay set until a per-input clear pulse removes them.

Top module: `tamper_detect`

## Requirements
- R1: After synchronous reset, `flag_o`, `irq_o`, `ts_req_o` and `precharge_o` are all 0.
- R2: With `filter_code_i` = 0 (edge mode), `polarity_i[n]` = 0 accepts a rising edge and 1 accepts a falling edge on `pin_i[n]`. The opposite edge is ignored. The flag is visible after the third rising clock edge that follows the pin change.
- R3: With `filter_code_i` = 1, 2 or 3 (level mode), an event is accepted at the 2nd, 4th or 8th consecutive sample point that sees the input active, and not at an earlier one.
- R4: In level mode, a single inactive sample resets the run of active samples to zero.
- R5: In level mode an input that stays active yields one event only. A new event needs at least one inactive sample first.
- R6: In level mode, `polarity_i[n]` = 0 makes a low input active and 1 makes a high input active.
- R7: Sample points fall on the clock cycles where the low (15 − `rate_code_i`) bits of a free-running cycle counter, started at 0 by reset, are all ones. This gives a period of 32768 >> `rate_code_i` cycles.
- R8: `precharge_o` is high in the 2^`precharge_code_i` cycles that end with each sample cycle. This holds only while the filter is on (code ≠ 0), at least one input is enabled, and pull-up is not disabled. Otherwise it is low.
- R9: `pullup_dis_i` = 1 holds `precharge_o` low, and level-mode detection still works.
- R10: An input whose `chan_en_i` bit is 0 never sets its flag.
- R11: A flag stays set until a one-cycle pulse on its `flag_clr_i` bit. The flag is 0 from the next cycle on unless a new event arrives.
- R12: `irq_o` is `int_en_i` AND (either flag), and it changes in the same cycle as the flags.
- R13: With `ts_en_i` = 1, each accepted event gives a one-cycle `ts_req_o` pulse in the cycle its flag is set. With `ts_en_i` = 0, no pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 2 | Raw tamper inputs (asynchronous) |
| chan_en_i | input | 2 | Per-input detection enable |
| polarity_i | input | 2 | Edge direction (edge mode) or active level (level mode) |
| filter_code_i | input | 2 | 0 edge mode; 1/2/3 need 2/4/8 active samples |
| rate_code_i | input | 3 | Sample period 32768 >> code cycles |
| precharge_code_i | input | 2 | Precharge length 2^code cycles |
| pullup_dis_i | input | 1 | Suppress precharge |
| int_en_i | input | 1 | Interrupt enable for both flags |
| ts_en_i | input | 1 | Accepted events request a timestamp |
| flag_clr_i | input | 2 | Per-input flag clear pulse |
| flag_o | output | 2 | Sticky tamper flags |
| irq_o | output | 1 | Interrupt |
| ts_req_o | output | 1 | Timestamp request pulse |
| precharge_o | output | 1 | Pull-up drive enable |

## Verification
A wrong state in the run counter shows up as a flag that is set one or more sample periods early or late. A flag that fires again during a steady active input points to the same kind of fault. The bench therefore pins the flag to the exact sample point, up to 512 cycles after the stimulus. A divider or window fault shows on `precharge_o` within one sample period, and every cycle of that period is compared. Edge-path and output-register faults show within three cycles.

// File: rtl/tamp_pkg.sv
package tamp_pkg;
  localparam int FILT_W = 2;

  typedef enum logic [FILT_W-1:0] {
    FILT_EDGE = 2'd0,
    FILT_RUN2 = 2'd1,
    FILT_RUN4 = 2'd2,
    FILT_RUN8 = 2'd3
  } filt_mode_e;
endpackage

// File: rtl/tamp_sync.sv
module tamp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/tamp_timebase.sv
module tamp_timebase #(
  parameter int DIV_LOG2 = 15,
  parameter int RATE_W   = 3,
  parameter int PRE_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_code_i,
  input  logic [PRE_W-1:0]  pre_code_i,
  input  logic              pc_allow_i,
  output logic              sample_tick_o,
  output logic              precharge_o
);
  localparam int EXT_W = DIV_LOG2 + 1;

  logic [DIV_LOG2-1:0] cnt_q, cnt_nx, period_mask;
  logic [EXT_W-1:0]    span, low_nx_ext, mask_ext;
  logic                win_nx, pc_q;

  // period = mask + 1 = 2^(DIV_LOG2 - rate)
  assign period_mask = {DIV_LOG2{1'b1}} >> rate_code_i;
  assign cnt_nx      = cnt_q + DIV_LOG2'(1);
  assign span        = EXT_W'(1) << pre_code_i;
  assign low_nx_ext  = {1'b0, cnt_nx & period_mask};
  assign mask_ext    = {1'b0, period_mask};
  // window: last 'span' cycles of each period, ending on the sample cycle
  assign win_nx      = (low_nx_ext + span) > mask_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pc_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      pc_q  <= pc_allow_i & win_nx;
    end
  end

  assign sample_tick_o = (cnt_q & period_mask) == period_mask;
  assign precharge_o   = pc_q;
endmodule

// File: rtl/tamp_chan.sv
module tamp_chan #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_i,
  input  logic             en_i,
  input  logic             pol_i,
  input  logic             level_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic             tick_i,
  output logic             ev_o
);
  logic             s_d;
  logic [CNT_W-1:0] run_q, run_nx;
  logic             active, at_last, edge_ev, lvl_ev;

  assign active  = (s_i == pol_i);
  assign at_last = (run_q == thr_i - CNT_W'(1));

  always_comb begin
    run_nx = run_q;
    if (!en_i || !level_i) begin
      run_nx = '0;
    end else if (tick_i) begin
      if (!active)             run_nx = '0;
      else if (run_q != thr_i) run_nx = run_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_d   <= 1'b0;
      run_q <= '0;
    end else begin
      s_d   <= s_i;
      run_q <= run_nx;
    end
  end

  assign edge_ev = en_i & ~level_i & (pol_i ? (s_d & ~s_i) : (s_i & ~s_d));
  assign lvl_ev  = en_i & level_i & tick_i & active & at_last;
  assign ev_o    = edge_ev | lvl_ev;
endmodule

// File: rtl/tamper_detect.sv
module tamper_detect
  import tamp_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int DIV_LOG2 = 15,
  parameter int RATE_W   = 3,
  parameter int PRE_W    = 2,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic [NUM_CH-1:0] chan_en_i,
  input  logic [NUM_CH-1:0] polarity_i,
  input  logic [FILT_W-1:0] filter_code_i,
  input  logic [RATE_W-1:0] rate_code_i,
  input  logic [PRE_W-1:0]  precharge_code_i,
  input  logic              pullup_dis_i,
  input  logic              int_en_i,
  input  logic              ts_en_i,
  input  logic [NUM_CH-1:0] flag_clr_i,
  output logic [NUM_CH-1:0] flag_o,
  output logic              irq_o,
  output logic              ts_req_o,
  output logic              precharge_o
);
  localparam int MAX_THR = 1 << ((1 << FILT_W) - 1);
  localparam int CNT_W   = $clog2(MAX_THR + 1);

  filt_mode_e        mode;
  logic              level_mode, tick, pc_allow;
  logic [CNT_W-1:0]  thr;
  logic [NUM_CH-1:0] pin_s, ev, flag_q, flag_nx;
  logic              irq_q, ts_q;

  assign mode       = filt_mode_e'(filter_code_i);
  assign level_mode = (mode != FILT_EDGE);
  assign thr        = CNT_W'(1) << filter_code_i;
  assign pc_allow   = level_mode & ~pullup_dis_i & (|chan_en_i);

  tamp_sync #(.W(NUM_CH), .STAGES(SYNC_N)) u_sync (
    .clk (clk), .rst (rst), .d_i (pin_i), .q_o (pin_s)
  );

  tamp_timebase #(.DIV_LOG2(DIV_LOG2), .RATE_W(RATE_W), .PRE_W(PRE_W)) u_tb (
    .clk           (clk),
    .rst           (rst),
    .rate_code_i   (rate_code_i),
    .pre_code_i    (precharge_code_i),
    .pc_allow_i    (pc_allow),
    .sample_tick_o (tick),
    .precharge_o   (precharge_o)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tamp_chan #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .s_i     (pin_s[g]),
      .en_i    (chan_en_i[g]),
      .pol_i   (polarity_i[g]),
      .level_i (level_mode),
      .thr_i   (thr),
      .tick_i  (tick),
      .ev_o    (ev[g])
    );
  end

  // a new event wins over a clear in the same cycle
  assign flag_nx = (flag_q & ~flag_clr_i) | ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq_q  <= 1'b0;
      ts_q   <= 1'b0;
    end else begin
      flag_q <= flag_nx;
      irq_q  <= int_en_i & (|flag_nx);
      ts_q   <= ts_en_i & (|ev);
    end
  end

  assign flag_o   = flag_q;
  assign irq_o    = irq_q;
  assign ts_req_o = ts_q;
endmodule

// File: rtl/tamp_detect_chk.sv
module tamp_detect_chk #(
  parameter int NUM_CH = 2,
  parameter int FW     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] chan_en_i,
  input logic [FW-1:0]     filter_code_i,
  input logic              pullup_dis_i,
  input logic [NUM_CH-1:0] flag_clr_i,
  input logic [NUM_CH-1:0] flag_o,
  input logic              irq_o,
  input logic              ts_req_o,
  input logic              precharge_o
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (flag_o == '0 && !irq_o && !ts_req_o && !precharge_o));

  a_r11_flag0_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_o[0] && !flag_clr_i[0]) |=> flag_o[0]);

  a_r11_flag1_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_o[1] && !flag_clr_i[1]) |=> flag_o[1]);

  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (!chan_en_i[0] && !flag_o[0]) |=> !flag_o[0]);

  a_r12_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (|flag_o));

  a_r13_ts_with_flag: assert property (@(posedge clk) disable iff (rst)
    ts_req_o |-> (|flag_o));

  a_r9_pullup_off: assert property (@(posedge clk) disable iff (rst)
    pullup_dis_i |=> !precharge_o);

  a_r8_pc_level_only: assert property (@(posedge clk) disable iff (rst)
    precharge_o |-> ($past(filter_code_i) != '0));
endmodule

bind tamper_detect tamp_detect_chk #(.NUM_CH(NUM_CH), .FW(tamp_pkg::FILT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .chan_en_i     (chan_en_i),
  .filter_code_i (filter_code_i),
  .pullup_dis_i  (pullup_dis_i),
  .flag_clr_i    (flag_clr_i),
  .flag_o        (flag_o),
  .irq_o         (irq_o),
  .ts_req_o      (ts_req_o),
  .precharge_o   (precharge_o)
);

// File: tb/tb_tamper_detect.sv
`timescale 1ns/1ps
module tb_tamper_detect;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pin = '0, en = '0, pol = '0, filt = '0, pre = '0, clr = '0;
  logic [2:0] rate = 3'd7;
  logic       pudis = 1'b0, int_en = 1'b0, ts_en = 1'b0;
  logic [1:0] flag;
  logic       irq, ts, pc;
  int         tbcnt = 0;
  int         n_cmp = 0, n_err = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  tamper_detect dut (
    .clk (clk), .rst (rst), .pin_i (pin), .chan_en_i (en), .polarity_i (pol),
    .filter_code_i (filt), .rate_code_i (rate), .precharge_code_i (pre),
    .pullup_dis_i (pudis), .int_en_i (int_en), .ts_en_i (ts_en),
    .flag_clr_i (clr), .flag_o (flag), .irq_o (irq), .ts_req_o (ts),
    .precharge_o (pc)
  );

  // free-running cycle count since reset (R7 time reference)
  always @(posedge clk) begin
    if (rst) tbcnt <= 0;
    else     tbcnt <= tbcnt + 1;
  end

  function automatic int pmask();
    return 32'h7fff >> rate;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, tbcnt);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // returns at the negedge just after a sample posedge
  task automatic wait_sampled();
    do @(negedge clk); while (((tbcnt & pmask()) != 0) || tbcnt == 0);
  endtask

  task automatic clear_all();
    clr = 2'b11; cyc(1); clr = 2'b00; cyc(1);
  endtask

  task automatic pc_sweep(string req, int ncyc);
    for (int i = 0; i < ncyc; i++) begin
      logic e;
      e = (filt != 0) && !pudis && (|en) &&
          (((tbcnt & pmask()) + (1 << pre)) > pmask());
      chk(req, {31'd0, pc}, {31'd0, e});
      cyc(1);
    end
  endtask

  initial begin
    #(4 * 190000);
    n_err++;
    $display("FAIL watchdog expired");
    if (!done) $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk("R1 flag", {30'd0, flag}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 ts", {31'd0, ts}, 0);
    chk("R1 pc", {31'd0, pc}, 0);

    // ---- edge mode ----
    en = 2'b11; pol = 2'b10; int_en = 1; ts_en = 1; filt = 0;
    cyc(3);
    pin[1] = 1'b1;                      // rising on falling-edge input
    cyc(5);
    chk("R2 wrong edge ch1", {31'd0, flag[1]}, 0);
    pin[0] = 1'b1;
    cyc(2);
    chk("R2 latency early", {31'd0, flag[0]}, 0);
    cyc(1);
    chk("R2 rising ch0", {31'd0, flag[0]}, 1);
    chk("R12 irq with flag", {31'd0, irq}, 1);
    chk("R13 ts pulse", {31'd0, ts}, 1);
    cyc(1);
    chk("R13 ts one cycle", {31'd0, ts}, 0);
    chk("R11 sticky", {31'd0, flag[0]}, 1);
    clr = 2'b01; cyc(1); clr = 2'b00;
    chk("R11 cleared", {31'd0, flag[0]}, 0);
    chk("R12 irq after clear", {31'd0, irq}, 0);
    pc_sweep("R8 edge mode pc low", 300);
    pin[0] = 1'b0;
    cyc(5);
    chk("R2 falling ignored ch0", {31'd0, flag[0]}, 0);
    pin[1] = 1'b0;
    cyc(3);
    chk("R2 falling ch1", {31'd0, flag[1]}, 1);
    chk("R13 ts ch1", {31'd0, ts}, 1);
    int_en = 0; cyc(1);
    chk("R12 irq gated", {31'd0, irq}, 0);
    chk("R11 flag held", {31'd0, flag[1]}, 1);
    int_en = 1; cyc(1);
    chk("R12 irq regated", {31'd0, irq}, 1);
    clear_all();
    ts_en = 0;
    pin[0] = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 6; i++) begin cyc(1); if (ts) seen++; end
      chk("R13 ts disabled", seen, 0);
    end
    chk("R2 event without ts", {31'd0, flag[0]}, 1);
    pin[0] = 1'b0; clear_all();
    en = 2'b10;
    pin[0] = 1'b1; cyc(6);
    chk("R10 disabled ch0", {31'd0, flag[0]}, 0);
    pin[0] = 1'b0; cyc(3);
    en = 2'b11;

    // ---- level mode: ch0 high-active, ch1 low-active ----
    pol = 2'b01; pin = 2'b10; rate = 3'd7; pre = 0; ts_en = 1;
    for (int f = 1; f <= 3; f++) begin
      int thr;
      thr = 1 << f;
      filt = 2'(f);
      clear_all();
      wait_sampled(); wait_sampled();
      pin[0] = 1'b1;
      for (int k = 1; k < thr; k++) begin
        wait_sampled();
        chk("R3 not yet", {31'd0, flag[0]}, 0);
      end
      wait_sampled();
      chk("R3 threshold reached", {31'd0, flag[0]}, 1);
      pin[0] = 1'b0;
    end
    // R4 broken run
    filt = 2'd2; clear_all(); wait_sampled();
    pin[0] = 1'b1;
    repeat (3) wait_sampled();
    pin[0] = 1'b0;
    wait_sampled();
    pin[0] = 1'b1;
    repeat (3) wait_sampled();
    chk("R4 run restarted", {31'd0, flag[0]}, 0);
    wait_sampled();
    chk("R4 run complete", {31'd0, flag[0]}, 1);
    // R5 once per episode
    clear_all();
    repeat (5) wait_sampled();
    chk("R5 no retrigger", {31'd0, flag[0]}, 0);
    pin[0] = 1'b0; wait_sampled();
    pin[0] = 1'b1;
    repeat (3) wait_sampled();
    chk("R5 rearm not yet", {31'd0, flag[0]}, 0);
    wait_sampled();
    chk("R5 rearmed", {31'd0, flag[0]}, 1);
    pin[0] = 1'b0; clear_all();
    // R6 low-active ch1
    filt = 2'd1; wait_sampled();
    pin[1] = 1'b0;
    wait_sampled();
    chk("R6 low active first", {31'd0, flag[1]}, 0);
    wait_sampled();
    chk("R6 low active ch1", {31'd0, flag[1]}, 1);
    chk("R6 ch0 low inactive", {31'd0, flag[0]}, 0);
    pin[1] = 1'b1; clear_all();
    // R7 sample instant at rate 6
    rate = 3'd6; wait_sampled(); wait_sampled();
    pin[0] = 1'b1;
    wait_sampled();
    while ((tbcnt & pmask()) != pmask()) cyc(1);
    chk("R7 before sample", {31'd0, flag[0]}, 0);
    cyc(1);
    chk("R7 at sample", {31'd0, flag[0]}, 1);
    pin[0] = 1'b0; clear_all();

    // R8 precharge window sweep
    filt = 2'd1;
    for (int r = 3; r <= 7; r++) begin
      for (int p = 0; p < 4; p++) begin
        rate = 3'(r); pre = 2'(p); cyc(2);
        pc_sweep("R8 window", 32768 >> r);
      end
    end
    rate = 3'd0; pre = 2'd3; cyc(2);
    pc_sweep("R8 slowest rate", 32768);

    // R9 pull-up disabled
    rate = 3'd7; pre = 2'd3; pudis = 1; cyc(2);
    pc_sweep("R9 pc off", 300);
    clear_all(); wait_sampled();
    pin[0] = 1'b1;
    wait_sampled(); wait_sampled();
    chk("R9 detect without precharge", {31'd0, flag[0]}, 1);
    pin[0] = 1'b0;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule